// File: doc/BRIEF.md
# Word-Interleaved Multi-Bank Refill Memory

This block serves cache-line refills from a memory made of several one-word-wide banks that share a one-word return bus. A request carries a word address and a length code selecting a refill of one, two or four words. The address is placed on the banks once, during a single address phase. Every bank that holds a word of the refill then performs its access at the same time as the others. The words then leave one after another, each in its own bus transfer slot. A refill of n words therefore costs one address phase, one access time, and n transfer slots. The alternative of n complete sequential accesses is avoided.

Bank selection uses the low-order bits of the word address, because the bank count is a power of two. The word's row inside its bank comes from the remaining high-order bits. The bank arrays are internal registers whose contents are set at reset from a fixed arithmetic pattern, so a requester can predict every returned word. Only one refill is in flight at a time. The requester sees a ready flag, one data-valid pulse per word, and a completion pulse.

Top module: `imem_interleave`

## Requirements
- R1: After reset, req_ready is 1 and rdata_valid, refill_done and rdata are all 0.
- R2: The word at word address a is held in bank (a mod 4) at row (a >> 2). Its reset content is ((a * 32'h0100_0193) mod 2^32) XOR 32'h5A5A_1234.
- R3: Length code 0 returns 1 word, code 1 returns 2 words, and code 2 returns 4 words. The spare code 3 also returns 4 words. Exactly that many rdata_valid pulses occur per refill.
- R4: The low log2(n) bits of req_addr are ignored for an n-word refill. Words are returned in ascending address order, starting from the address rounded down to a multiple of n.
- R5: Take the clock edge that accepts a request as edge 0. The k-th word (k counted from 0) has rdata_valid high for exactly one cycle, the cycle that follows edge 31+4k. This is 4 address cycles plus 24 access cycles plus 4 cycles for each transfer slot, and the pulse falls on the last cycle of its slot.
- R6: refill_done is high for exactly one cycle, the cycle right after the last word's valid cycle. req_ready is high again in that same cycle.
- R7: req_ready is low from the accepting edge until the refill completes. A request presented while req_ready is low is ignored and does not change the data or timing of the refill in progress.
- R8: rdata is 0 in every cycle in which rdata_valid is 0.
- R9: A request held in the refill_done cycle is accepted at the next edge, so refills can follow each other with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_addr | input | 6 | Word address of the refill |
| req_len | input | 2 | Length code: 0 gives 1 word, 1 gives 2 words, 2 or 3 gives 4 words |
| rdata_valid | output | 1 | Returned word present on rdata |
| rdata | output | 32 | Returned word |
| refill_done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds the block with its default parameters: four banks of sixteen rows, 32-bit words, and phase lengths of 4, 24 and 4 cycles. This puts all 64 word addresses within reach, including the top address and every alignment of the three refill sizes. The four-cycle slot leaves room to show that each valid pulse is isolated. The 28-cycle lead-in is long enough to inject a second request while the block is busy. Random requests are mixed with directed cases for misaligned addresses, the spare length code, and back-to-back refills.

// File: rtl/imem_pkg.sv
package imem_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACCESS,
    PH_XFER
  } phase_e;

  // Reset content of the word at global word address a.
  function automatic logic [31:0] fill_word(input int unsigned a);
    logic [31:0] prod;
    prod = 32'(a) * 32'h0100_0193;
    return prod ^ 32'h5A5A_1234;
  endfunction

  // Number of words for a length code; codes beyond the bank span clamp.
  function automatic int unsigned words_of(input int unsigned code,
                                           input int unsigned log2nb);
    return (code >= log2nb) ? (32'd1 << log2nb) : (32'd1 << code);
  endfunction

  // Cycles from acceptance to the last word's valid cycle.
  function automatic int unsigned refill_cycles(input int unsigned n,
                                                input int unsigned a_cyc,
                                                input int unsigned c_cyc,
                                                input int unsigned x_cyc);
    return a_cyc + c_cyc + x_cyc * n;
  endfunction

endpackage

// File: rtl/imem_bank.sv
module imem_bank #(
  parameter int WORD_W  = 32,
  parameter int DEPTH   = 16,
  parameter int IDX_W   = 4,
  parameter int NB      = 4,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_q
);

  logic [WORD_W-1:0] mem [DEPTH];

  // Contents are loaded from the fill pattern at reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= WORD_W'(imem_pkg::fill_word(i * NB + BANK_ID));
      end
    end
  end

  // One access per refill; the word is held for the transfer slots.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_fire) begin
      rd_q <= mem[rd_idx];
    end
  end

endmodule

// File: rtl/imem_seq.sv
module imem_seq #(
  parameter int ADDR_CYC = 4,
  parameter int ACC_CYC  = 24,
  parameter int XFER_CYC = 4,
  parameter int CNT_W    = 5,
  parameter int K_W      = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [K_W-1:0] nwords,
  output logic           ready,
  output logic           accept,
  output logic           acc_done,
  output logic           slot_end,
  output logic           last_word,
  output logic [K_W-1:0] word_idx,
  output logic           done
);
  import imem_pkg::*;

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] ACC_LAST  = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(XFER_CYC - 1);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             addr_done;

  assign ready     = (phase == PH_IDLE);
  assign accept    = req_valid && ready;
  assign addr_done = (phase == PH_ADDR) && (cnt == ADDR_LAST);
  assign acc_done  = (phase == PH_ACCESS) && (cnt == ACC_LAST);
  assign slot_end  = (phase == PH_XFER) && (cnt == XFER_LAST);
  assign last_word = slot_end && (word_idx == nwords - K_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      word_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_word;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase    <= PH_ADDR;
            cnt      <= '0;
            word_idx <= '0;
          end
        end
        PH_ADDR: begin
          if (addr_done) begin
            phase <= PH_ACCESS;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_ACCESS: begin
          if (acc_done) begin
            phase <= PH_XFER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_XFER: begin
          if (slot_end) begin
            cnt <= '0;
            if (last_word) phase <= PH_IDLE;
            else           word_idx <= word_idx + K_W'(1);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  // R6
  done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_word |=> (done && ready));

  // R7
  slot_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> !ready);

  generate
    if (XFER_CYC > 1) begin : g_pulse
      // R5
      slot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> !slot_end);
    end
  endgenerate

endmodule

// File: rtl/imem_lane_sel.sv
module imem_lane_sel #(
  parameter int WORD_W = 32,
  parameter int NB     = 4,
  parameter int LOG_NB = 2,
  parameter int K_W    = 3
) (
  input  logic [NB-1:0][WORD_W-1:0] bank_q,
  input  logic [LOG_NB-1:0]         base_bank,
  input  logic [K_W-1:0]            word_idx,
  input  logic                      valid,
  output logic [WORD_W-1:0]         rdata
);

  logic [LOG_NB-1:0] lane;

  // Bank index wraps modulo the bank count.
  assign lane  = base_bank + word_idx[LOG_NB-1:0];
  assign rdata = valid ? bank_q[lane] : '0;

endmodule

// File: rtl/imem_interleave.sv
module imem_interleave #(
  parameter int WORD_W   = 32,
  parameter int NB       = 4,
  parameter int DEPTH    = 16,
  parameter int ADDR_CYC = 4,
  parameter int ACC_CYC  = 24,
  parameter int XFER_CYC = 4,
  localparam int LOG_NB  = $clog2(NB),
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int ADDR_W  = LOG_NB + IDX_W,
  localparam int LEN_W   = $clog2(LOG_NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rdata_valid,
  output logic [WORD_W-1:0] rdata,
  output logic              refill_done
);

  localparam int MAX_CYC = (ACC_CYC > ADDR_CYC) ?
                           ((ACC_CYC > XFER_CYC) ? ACC_CYC : XFER_CYC) :
                           ((ADDR_CYC > XFER_CYC) ? ADDR_CYC : XFER_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int K_W     = LOG_NB + 1;

  logic [K_W-1:0]           req_words;
  logic [ADDR_W-1:0]        base_next;
  logic [ADDR_W-1:0]        base_q;
  logic [K_W-1:0]           nwords_q;
  logic                     accept;
  logic                     acc_done;
  logic                     slot_end;
  logic                     last_word;
  logic [K_W-1:0]           word_idx;
  logic [NB-1:0]            fire_mask;
  logic [NB-1:0][WORD_W-1:0] bank_q;
  logic [LOG_NB-1:0]        base_bank;
  logic [IDX_W-1:0]         base_row;

  assign req_words = K_W'(imem_pkg::words_of(32'(req_len), LOG_NB));
  assign base_next = req_addr & ~(ADDR_W'(req_words) - ADDR_W'(1));
  assign base_bank = base_q[LOG_NB-1:0];
  assign base_row  = base_q[ADDR_W-1:LOG_NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      nwords_q <= K_W'(1);
    end else if (accept) begin
      base_q   <= base_next;
      nwords_q <= req_words;
    end
  end

  imem_seq #(
    .ADDR_CYC (ADDR_CYC),
    .ACC_CYC  (ACC_CYC),
    .XFER_CYC (XFER_CYC),
    .CNT_W    (CNT_W),
    .K_W      (K_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .nwords    (nwords_q),
    .ready     (req_ready),
    .accept    (accept),
    .acc_done  (acc_done),
    .slot_end  (slot_end),
    .last_word (last_word),
    .word_idx  (word_idx),
    .done      (refill_done)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [LOG_NB-1:0] offs;
      // Position of this bank inside the refill, modulo the bank count.
      assign offs         = LOG_NB'(b) - base_bank;
      assign fire_mask[b] = acc_done && ({1'b0, offs} < nwords_q);

      imem_bank #(
        .WORD_W  (WORD_W),
        .DEPTH   (DEPTH),
        .IDX_W   (IDX_W),
        .NB      (NB),
        .BANK_ID (b)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_fire (fire_mask[b]),
        .rd_idx  (base_row),
        .rd_q    (bank_q[b])
      );
    end
  endgenerate

  assign rdata_valid = slot_end;

  imem_lane_sel #(
    .WORD_W (WORD_W),
    .NB     (NB),
    .LOG_NB (LOG_NB),
    .K_W    (K_W)
  ) u_sel (
    .bank_q    (bank_q),
    .base_bank (base_bank),
    .word_idx  (word_idx),
    .valid     (slot_end),
    .rdata     (rdata)
  );

  // R3
  fire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> ($countones(fire_mask) == 32'(nwords_q)));

  // R4
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((base_q & (ADDR_W'(nwords_q) - ADDR_W'(1))) == '0));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !refill_done) |=> $stable(base_q));

  // R6
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_done |-> (req_ready && !rdata_valid));

endmodule

// File: tb/tb_imem_interleave.sv
`timescale 1ns/1ps
module tb_imem_interleave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_addr = '0;
  logic [1:0]  req_len = '0;
  logic        rdata_valid;
  logic [31:0] rdata;
  logic        refill_done;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  imem_interleave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .rdata_valid (rdata_valid),
    .rdata       (rdata),
    .refill_done (refill_done)
  );

  // Pattern restated with shifts and adds instead of a multiply.
  function automatic logic [31:0] exp_word(input int unsigned a);
    logic [31:0] v;
    v = 32'(a);
    return ((v << 24) + (v << 8) + (v << 7) + (v << 4) + (v << 1) + v)
           ^ 32'h5A5A_1234;
  endfunction

  function automatic int unsigned exp_len(input int unsigned code);
    case (code)
      0: return 1;
      1: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Entered on a negedge with the block idle; returns on the done negedge.
  task automatic refill(input int unsigned addr, input int unsigned code,
                        input bit inject);
    int unsigned n, base, k, done_s;
    n      = exp_len(code);
    base   = addr & ~(n - 1);
    done_s = 4 + 24 + 4 * n + 1;
    k      = 0;
    check(req_ready, "R9 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = 6'(addr);
    req_len   = 2'(code);
    for (int s = 1; s <= done_s; s++) begin
      @(negedge clk);
      if (s == 1) req_valid = 1'b0;
      if (inject && s == 10) begin
        req_valid = 1'b1;
        req_addr  = 6'($urandom);
        req_len   = 2'($urandom);
      end
      if (inject && s == 11) req_valid = 1'b0;
      if (rdata_valid) begin
        check(s == 32 + 4 * k, "R5 valid cycle", 32'(s), 32'(32 + 4 * k));
        check(rdata == exp_word((base + k) % 64), "R2 R4 data",
              rdata, exp_word((base + k) % 64));
        k++;
      end else begin
        if (rdata != 0) check(1'b0, "R8 idle data", rdata, 32'd0);
        if (s == 32 + 4 * k && k < n)
          check(1'b0, "R5 missing valid", 32'(s), 32'(32 + 4 * k));
      end
      if (s < done_s) begin
        if (req_ready || refill_done)
          check(1'b0, "R7 busy flags", {30'd0, req_ready, refill_done}, 32'd0);
      end else begin
        check(refill_done && req_ready, "R6 done and ready",
              {30'd0, req_ready, refill_done}, 32'd3);
        check(k == n, "R3 word count", 32'(k), 32'(n));
      end
    end
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rdata_valid && !refill_done && rdata == 0,
          "R1 reset state",
          {rdata[28:0], req_ready, rdata_valid, refill_done}, 32'b100);
    refill(5, 0, 0);          idle(2);  // R3 single word
    refill(6, 1, 0);          idle(2);  // R3 two words
    refill(8, 2, 0);          idle(1);  // R3 four words
    refill(15, 3, 0);         idle(2);  // R3 spare code, R4 rounds to 12
    refill(11, 1, 0);         idle(2);  // R4 misaligned pair -> 10
    refill(63, 0, 0);         idle(2);  // R2 top address
    refill(62, 2, 1);                   // R7 request ignored while busy
    refill(3, 1, 0);                    // R9 back-to-back
    refill(20, 2, 0);         idle(2);  // R9 back-to-back
    for (int i = 0; i < 24; i++) begin
      refill($urandom % 64, $urandom % 4, ($urandom % 3) == 0);
      if ($urandom % 2) idle(1 + $urandom % 3);
    end
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule